// File: doc/BRIEF.md
# Chip Test and Configuration Controller

This block links a narrow set of external configuration pins to a processor's on-chip instruction and data memories. The chip has no flash and no external memory, so every program and data word has to arrive through this port. A 32-bit word is assembled from byte transfers, written into the selected memory, and the address then advances by itself. The same pins also read memory contents back out, so results can be compared with expected values.

The controller moves through three phases: load, run and done. In the load phase the core is held idle and memory is filled. A start command releases the core and raises a run-window output, which gives the exact start of the program for power measurement. When the core reports completion, the window closes on that cycle and the core is held idle again. The port then accepts reads, writes and another start.

Every transfer has the same form. A strobe marks one transfer, a 2-bit command says what it is, a select bit picks instruction or data memory, and an 8-bit data field carries the byte.

Top module: `cfg_test_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `core_en`, `run_active`, `cfg_rready`, `imem_we`, `dmem_we`, `imem_re` and `dmem_re` are all 0.
- R2: A strobe with command 00 (set address) shifts `cfg_data` into the low 8 bits of the address register. The older bits move up by 8 and bits above ADDR_W are dropped. The strobe also resets the byte position of both the write and the read assembly to byte 0.
- R3: Four strobes with command 01 (write) place their bytes in bits [8k+7:8k] for k = 0,1,2,3, least significant byte first. On the cycle after the edge that samples the fourth strobe, a one-cycle write enable is high, with `mem_addr` equal to the current address and `mem_wdata` equal to the assembled word. The address then increments by 1.
- R4: `cfg_sel` = 0 selects instruction memory and 1 selects data memory. A write or read access pulses only the enable of the selected memory, and at most one of the four memory enables is high in any cycle.
- R5: A strobe with command 11 (start), made while the core is not running, raises `core_en` and `run_active` on the cycle after the sampling edge.
- R6: While the core runs, all configuration strobes are ignored: there is no memory enable, no `cfg_rready`, and the address does not change. `core_done` sampled while running drops `core_en` and `run_active` at that edge. `core_done` is ignored while the core is not running.
- R7: A strobe with command 10 (read) for byte k produces a one-cycle `cfg_rready` three edges after the sampling edge, with `cfg_rdata` equal to bits [8k+7:8k] of the word at the current address. Byte 0 triggers a one-cycle read enable to the selected memory, and the fourth byte increments the address.
- R8: After completion, write, read and start commands are accepted again, and the address is the one held before the run.
- R9: An address increment from the highest address wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Strobe, one transfer per cycle it is high |
| cfg_cmd | input | 2 | 00 set address, 01 write byte, 10 read byte, 11 start |
| cfg_sel | input | 1 | 0 instruction memory, 1 data memory |
| cfg_data | input | 8 | Byte in |
| cfg_rdata | output | 8 | Byte out during read-back |
| cfg_rready | output | 1 | One-cycle pulse, `cfg_rdata` valid |
| core_en | output | 1 | Releases the core when high |
| core_done | input | 1 | End-of-program flag from the core |
| run_active | output | 1 | Program run window |
| mem_addr | output | ADDR_W (10) | Word address for either memory |
| mem_wdata | output | WORD_W (32) | Word to write |
| imem_we | output | 1 | Instruction memory write enable |
| dmem_we | output | 1 | Data memory write enable |
| imem_re | output | 1 | Instruction memory read enable |
| dmem_re | output | 1 | Data memory read enable |
| imem_rdata | input | WORD_W (32) | Instruction memory read word, one cycle after enable |
| dmem_rdata | input | WORD_W (32) | Data memory read word, one cycle after enable |

## Verification
The main function is driven with a sweep that writes 64 consecutive words into each memory and then reads them all back. Each word carries a different arithmetic pattern, and a different pattern is used for each memory. A mix-up between byte lanes, addresses or the two memories therefore shows up as a data mismatch. Further patterns cover three separate cases: a multi-byte address shift, a half-written word cut short by an address set, and writes across the top of the address space, which check truncation, index reset and wrap respectively. Commands issued during a run, and a done flag raised before any run, show that the run window gates the port and only the completion handshake closes it.

// File: rtl/cfg_test_pkg.sv
package cfg_test_pkg;
  typedef enum logic [1:0] {
    CMD_ADDR  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_START = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    PH_LOAD = 2'b00,
    PH_RUN  = 2'b01,
    PH_DONE = 2'b10
  } phase_e;
endpackage

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
  import cfg_test_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_req,
  input  logic   core_done,
  output phase_e phase,
  output logic   core_en,
  output logic   run_active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_LOAD;
      core_en    <= 1'b0;
      run_active <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD, PH_DONE: begin
          if (start_req) begin
            phase      <= PH_RUN;
            core_en    <= 1'b1;
            run_active <= 1'b1;
          end
        end
        PH_RUN: begin
          if (core_done) begin
            phase      <= PH_DONE;
            core_en    <= 1'b0;
            run_active <= 1'b0;
          end
        end
        default: begin
          phase      <= PH_LOAD;
          core_en    <= 1'b0;
          run_active <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PORT_W-1:0] load_byte,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  localparam int SH_W = ADDR_W + PORT_W;
  logic [SH_W-1:0] shifted;

  assign shifted = {addr, load_byte};

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= shifted[ADDR_W-1:0];
    else if (inc)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/cfg_word_writer.sv
module cfg_word_writer #(
  parameter int WORD_W = 32,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              sel,
  input  logic              clear,
  input  logic [PORT_W-1:0] din,
  output logic              issue,
  output logic              imem_we,
  output logic              dmem_we,
  output logic [WORD_W-1:0] wdata
);
  localparam int BEATS = WORD_W / PORT_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] asm_nxt;

  assign issue = stb && (idx_q == IDX_W'(BEATS - 1));

  always_comb begin
    asm_nxt = asm_q;
    asm_nxt[idx_q*PORT_W +: PORT_W] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      asm_q   <= '0;
      wdata   <= '0;
      imem_we <= 1'b0;
      dmem_we <= 1'b0;
    end else begin
      imem_we <= 1'b0;
      dmem_we <= 1'b0;
      if (clear) begin
        idx_q <= '0;
      end else if (stb) begin
        asm_q <= asm_nxt;
        if (issue) begin
          idx_q   <= '0;
          wdata   <= asm_nxt;
          imem_we <= !sel;
          dmem_we <= sel;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_word_reader.sv
module cfg_word_reader #(
  parameter int WORD_W = 32,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              sel,
  input  logic              clear,
  input  logic [WORD_W-1:0] imem_rdata,
  input  logic [WORD_W-1:0] dmem_rdata,
  output logic              issue,
  output logic              last,
  output logic              imem_re,
  output logic              dmem_re,
  output logic [PORT_W-1:0] rbyte,
  output logic              rready
);
  localparam int BEATS = WORD_W / PORT_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [IDX_W-1:0]  idx_q, p1_idx, p2_idx;
  logic              p1_v, p2_v, p1_sel, p2_sel;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word;

  assign issue = stb && (idx_q == '0);
  assign last  = stb && (idx_q == IDX_W'(BEATS - 1));

  always_comb begin
    if (p2_idx == '0) word = p2_sel ? dmem_rdata : imem_rdata;
    else              word = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      p1_idx  <= '0;
      p2_idx  <= '0;
      p1_v    <= 1'b0;
      p2_v    <= 1'b0;
      p1_sel  <= 1'b0;
      p2_sel  <= 1'b0;
      hold_q  <= '0;
      imem_re <= 1'b0;
      dmem_re <= 1'b0;
      rbyte   <= '0;
      rready  <= 1'b0;
    end else begin
      imem_re <= 1'b0;
      dmem_re <= 1'b0;
      rready  <= 1'b0;
      if (clear) begin
        idx_q <= '0;
      end else if (stb) begin
        idx_q <= last ? '0 : idx_q + 1'b1;
        if (issue) begin
          imem_re <= !sel;
          dmem_re <= sel;
        end
      end
      p1_v   <= stb;
      p1_idx <= idx_q;
      p1_sel <= sel;
      p2_v   <= p1_v;
      p2_idx <= p1_idx;
      p2_sel <= p1_sel;
      if (p2_v) begin
        if (p2_idx == '0) hold_q <= word;
        rbyte  <= word[p2_idx*PORT_W +: PORT_W];
        rready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_test_ctrl.sv
module cfg_test_ctrl
  import cfg_test_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_cmd,
  input  logic              cfg_sel,
  input  logic [PORT_W-1:0] cfg_data,
  output logic [PORT_W-1:0] cfg_rdata,
  output logic              cfg_rready,
  output logic              core_en,
  input  logic              core_done,
  output logic              run_active,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              imem_we,
  output logic              dmem_we,
  output logic              imem_re,
  output logic              dmem_re,
  input  logic [WORD_W-1:0] imem_rdata,
  input  logic [WORD_W-1:0] dmem_rdata
);
  cmd_e              cmd;
  phase_e            phase;
  logic              port_ok;
  logic              addr_stb, wr_stb, rd_stb, go_stb;
  logic              wr_issue, rd_issue, rd_last;
  logic [ADDR_W-1:0] cur_addr;

  assign cmd      = cmd_e'(cfg_cmd);
  assign port_ok  = cfg_valid && (phase != PH_RUN);
  assign addr_stb = port_ok && (cmd == CMD_ADDR);
  assign wr_stb   = port_ok && (cmd == CMD_WRITE);
  assign rd_stb   = port_ok && (cmd == CMD_READ);
  assign go_stb   = port_ok && (cmd == CMD_START);

  cfg_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_req  (go_stb),
    .core_done  (core_done),
    .phase      (phase),
    .core_en    (core_en),
    .run_active (run_active)
  );

  cfg_addr_ctr #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (addr_stb),
    .load_byte (cfg_data),
    .inc       (wr_issue || rd_last),
    .addr      (cur_addr)
  );

  cfg_word_writer #(.WORD_W(WORD_W), .PORT_W(PORT_W)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .stb     (wr_stb),
    .sel     (cfg_sel),
    .clear   (addr_stb),
    .din     (cfg_data),
    .issue   (wr_issue),
    .imem_we (imem_we),
    .dmem_we (dmem_we),
    .wdata   (mem_wdata)
  );

  cfg_word_reader #(.WORD_W(WORD_W), .PORT_W(PORT_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .stb        (rd_stb),
    .sel        (cfg_sel),
    .clear      (addr_stb),
    .imem_rdata (imem_rdata),
    .dmem_rdata (dmem_rdata),
    .issue      (rd_issue),
    .last       (rd_last),
    .imem_re    (imem_re),
    .dmem_re    (dmem_re),
    .rbyte      (cfg_rdata),
    .rready     (cfg_rready)
  );

  always_ff @(posedge clk) begin
    if (rst)                        mem_addr <= '0;
    else if (wr_issue || rd_issue)  mem_addr <= cur_addr;
  end
endmodule

// File: rtl/cfg_test_ctrl_chk.sv
module cfg_test_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_valid,
  input logic [1:0] cfg_cmd,
  input logic       core_done,
  input logic       core_en,
  input logic       run_active,
  input logic       cfg_rready,
  input logic       imem_we,
  input logic       dmem_we,
  input logic       imem_re,
  input logic       dmem_re
);
  AST_ONE_MEM_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({imem_we, dmem_we, imem_re, dmem_re})); // R4

  AST_START_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(run_active) |-> $past(cfg_valid && cfg_cmd == 2'b11) && core_en); // R5

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    $fell(run_active) |-> $past(core_done) && !core_en); // R6

  AST_NO_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    (run_active && $past(run_active)) |-> !(imem_we || dmem_we || imem_re || dmem_re)); // R6

  AST_READ_READY_SOURCE: assert property (@(posedge clk) disable iff (rst)
    cfg_rready |-> $past(cfg_valid && cfg_cmd == 2'b10, 3)); // R7

  AST_READ_ENABLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (imem_re || dmem_re) |-> $past(cfg_valid && cfg_cmd == 2'b10)); // R7
endmodule

bind cfg_test_ctrl cfg_test_ctrl_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_valid  (cfg_valid),
  .cfg_cmd    (cfg_cmd),
  .core_done  (core_done),
  .core_en    (core_en),
  .run_active (run_active),
  .cfg_rready (cfg_rready),
  .imem_we    (imem_we),
  .dmem_we    (dmem_we),
  .imem_re    (imem_re),
  .dmem_re    (dmem_re)
);

// File: tb/test_cfg_test_ctrl.sv
`timescale 1ns/1ps
module test_cfg_test_ctrl;
  localparam int AW = 10;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_cmd = 2'b00;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_data = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        cfg_rready;
  logic        core_en;
  logic        core_done = 1'b0;
  logic        run_active;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        imem_we, dmem_we, imem_re, dmem_re;
  logic [31:0] imem_rdata, dmem_rdata;

  logic [31:0] imem [0:NW-1];
  logic [31:0] dmem [0:NW-1];
  logic [31:0] exp_i [0:NW-1];
  logic [31:0] exp_d [0:NW-1];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cfg_test_ctrl #(.ADDR_W(AW), .WORD_W(32), .PORT_W(8)) i_cfg_test_ctrl (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_rdata(cfg_rdata),
    .cfg_rready(cfg_rready), .core_en(core_en), .core_done(core_done),
    .run_active(run_active), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .imem_we(imem_we), .dmem_we(dmem_we), .imem_re(imem_re), .dmem_re(dmem_re),
    .imem_rdata(imem_rdata), .dmem_rdata(dmem_rdata));

  always @(posedge clk) begin
    if (imem_we) imem[mem_addr] <= mem_wdata;
    if (dmem_we) dmem[mem_addr] <= mem_wdata;
    if (imem_re) imem_rdata <= imem[mem_addr];
    if (dmem_re) dmem_rdata <= dmem[mem_addr];
  end

  function automatic logic [31:0] pat(input logic s, input int a);
    logic [31:0] t;
    t = 32'h9E3779B9 * 32'(a + 1);
    return t ^ (s ? 32'h5A5AC3C3 : 32'h0);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic s, input logic [7:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_cmd = c; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    send(2'b00, 1'b0, a[15:8]);
    send(2'b00, 1'b0, a[7:0]);
  endtask

  task automatic write_word(input string req, input logic s,
                            input logic [31:0] w, input logic [AW-1:0] ea);
    for (int k = 0; k < 4; k++) begin
      send(2'b01, s, w[8*k +: 8]);
      if (k < 3) chk(req, "no enable mid-word", {30'd0, imem_we, dmem_we}, 32'd0);
    end
    chk(req, "write enables {i,d}", {30'd0, imem_we, dmem_we}, {30'd0, !s, s});
    chk(req, "write address", 32'(mem_addr), 32'(ea));
    chk(req, "write data", mem_wdata, w);
    if (s) exp_d[ea] = w; else exp_i[ea] = w;
  endtask

  task automatic read_word(input string req, input logic s, input logic [31:0] ew);
    for (int k = 0; k < 4; k++) begin
      send(2'b10, s, 8'h00);
      if (k == 0) chk(req, "read enables {i,d}", {30'd0, imem_re, dmem_re}, {30'd0, !s, s});
      @(negedge clk);
      @(negedge clk);
      chk(req, "rready", 32'(cfg_rready), 32'd1);
      chk(req, "read byte", 32'(cfg_rdata), 32'(ew[8*k +: 8]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "outputs in reset", {25'd0, core_en, run_active, cfg_rready,
        imem_we, dmem_we, imem_re, dmem_re}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", {25'd0, core_en, run_active, cfg_rready,
        imem_we, dmem_we, imem_re, dmem_re}, 32'd0);

    // R6: done flag before any run is ignored
    core_done = 1'b1; @(negedge clk); core_done = 1'b0;
    chk("R6", "done before run", {30'd0, core_en, run_active}, 32'd0);

    // R3 R4: sweep 64 words into each memory from address 0
    for (int s = 0; s < 2; s++) begin
      set_addr(16'h0000);
      for (int a = 0; a < 64; a++) write_word("R3", s[0], pat(s[0], a), AW'(a));
    end

    // R2: three-byte address shift keeps the low ten bits
    send(2'b00, 1'b0, 8'hAB);
    send(2'b00, 1'b0, 8'h03);
    send(2'b00, 1'b0, 8'hFE);
    write_word("R2", 1'b1, 32'hCAFE0001, 10'h3FE);
    write_word("R9", 1'b1, 32'hCAFE0002, 10'h3FF);
    write_word("R9", 1'b1, 32'hCAFE0003, 10'h000);

    // R2: a half-written word is dropped by an address set
    send(2'b01, 1'b0, 8'h11);
    send(2'b01, 1'b0, 8'h22);
    set_addr(16'h0005);
    write_word("R2", 1'b0, 32'h76543210, 10'h005);

    // R5 R6: run window, port ignored while running
    set_addr(16'h0010);
    send(2'b11, 1'b0, 8'h00);
    chk("R5", "run started {en,active}", {30'd0, core_en, run_active}, 32'h3);
    send(2'b00, 1'b0, 8'h33);
    for (int k = 0; k < 4; k++) begin
      send(2'b01, 1'b1, 8'hEE);
      chk("R6", "no write enable in run", {30'd0, imem_we, dmem_we}, 32'd0);
    end
    send(2'b10, 1'b0, 8'h00);
    chk("R6", "no read enable in run", {30'd0, imem_re, dmem_re}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R6", "no rready in run", 32'(cfg_rready), 32'd0);
    chk("R6", "still running", {30'd0, core_en, run_active}, 32'h3);
    core_done = 1'b1; @(negedge clk); core_done = 1'b0;
    chk("R6", "done closes window", {30'd0, core_en, run_active}, 32'd0);

    // R8: address kept across the run, writes accepted again
    write_word("R8", 1'b1, 32'h0BADF00D, 10'h010);

    // R7 R8: read back both sweeps
    for (int s = 0; s < 2; s++) begin
      set_addr(16'h0000);
      for (int a = 0; a < 64; a++)
        read_word("R7", s[0], s[0] ? exp_d[a] : exp_i[a]);
    end
    set_addr(16'h03FE);
    read_word("R7", 1'b1, 32'hCAFE0001);
    read_word("R9", 1'b1, 32'hCAFE0002);
    read_word("R9", 1'b1, 32'hCAFE0003);

    // R8: restart from the done phase
    send(2'b11, 1'b0, 8'h00);
    chk("R8", "restart", {30'd0, core_en, run_active}, 32'h3);
    core_done = 1'b1; @(negedge clk); core_done = 1'b0;
    chk("R8", "second done", {30'd0, core_en, run_active}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule